// File: doc/BRIEF.md
# Partial-Word Store Byte Merger

This block turns a "store bytes" request into one aligned, byte-masked memory write. A request carries a byte address, a 64-bit register value, a fill mode and an access size. The fill mode is either begin or end. The access size is either a 32-bit word or a 64-bit doubleword. The block returns four things:

- the doubleword-aligned address;
- the write data placed on big-endian byte lanes;
- one write enable per lane;
- a probe flag.

Begin mode writes from the addressed byte to the last byte of the word. End mode writes from the first byte of the word up to, but not including, the addressed byte.

Every request yields exactly one write beat, so memory never sees a partial store split into pieces. This matters for odd sizes such as 3, 5, 6 or 7 bytes. End mode at offset zero enables no lanes. It still raises the probe flag, so the access is checked for permission and the line is marked dirty. Results are registered with one cycle of latency, and a new request can be accepted every cycle.

Top module: `sbyte_merge`

## Requirements
- R1: After reset `wr_valid` is 0. It stays 0 in every cycle that does not follow a clock edge with `req_valid` high.
- R2: `wr_addr` equals the request address with bits [2:0] cleared.
- R3: Lanes use big-endian numbering. Lane k is `wr_data[63-8k -: 8]` and sits at aligned address + k. Bit k of `wr_be` enables lane k. On enabled lanes, the data is the request value for a doubleword. For a word, both halves carry `req_value[31:0]`.
- R4: Word, begin (`req_end`=0, `req_dword`=0), with o = address bits [1:0]. Lanes o..3 of the selected half are enabled, which is 4-o bytes.
- R5: Word, end (`req_end`=1), with o = address bits [1:0]. Lanes 0..o-1 of the selected half are enabled. They hold the o most-significant bytes of `req_value[31:0]`.
- R6: In word mode, address bit 2 selects the half: 0 selects lanes 0..3 and 1 selects lanes 4..7. The other half has all enables at 0.
- R7: Doubleword, begin (`req_dword`=1), with o = address bits [2:0]. Lanes o..7 are enabled and carry the least-significant 8-o bytes of the value.
- R8: Doubleword, end, with o = address bits [2:0]. Lanes 0..o-1 are enabled and carry the o most-significant bytes of the value.
- R9: `wr_probe` is 1 only for end mode at offset 0: bits [1:0]=0 for a word, bits [2:0]=0 for a doubleword. In that case `wr_be` is all zero. In every other case `wr_probe` is 0 and at least one lane is enabled.
- R10: Requests on consecutive cycles each produce their own complete beat, one cycle later and in order. Every byte of a request, including 3, 5, 6 and 7-byte spans, appears in that single beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Byte address |
| req_value | input | DATA_W | Register value to store |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| req_dword | input | 1 | 0 = word, 1 = doubleword |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | ADDR_W | Doubleword-aligned address |
| wr_data | output | DATA_W | Lane-placed write data |
| wr_be | output | DATA_W/8 | Per-lane write enables |
| wr_probe | output | 1 | Probe-only access (no bytes written) |

## Verification
A wrong offset decode, or a wrong begin/end comparison, shows up on `wr_be` in the very next cycle: the span is shifted by one lane, reversed, or placed in the wrong half. A bad lane placement corrupts enabled bytes of `wr_data` on that same beat. A stuck payload register, or a missing load enable, appears as a stale address or mask on the beat after a change of request. Every offset in both modes and both sizes is therefore driven directly, and then mixed with random back-to-back traffic.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic {
    FILL_FROM_ADDR = 1'b0,
    FILL_TO_ADDR   = 1'b1
  } fill_mode_e;

  typedef struct packed {
    logic [63:0] data;
    logic [7:0]  be;
    logic        probe;
  } beat_t;
endpackage

// File: rtl/sbm_offset_decode.sv
module sbm_offset_decode #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] addr_lo,
  input  logic             dword,
  output logic [OFF_W-1:0] offset,
  output logic             half
);
  // Word accesses use the offset inside the half; the top bit picks the half.
  always_comb begin
    if (dword) offset = addr_lo;
    else       offset = {1'b0, addr_lo[OFF_W-2:0]};
    half = addr_lo[OFF_W-1];
  end
endmodule

// File: rtl/sbm_mask_gen.sv
module sbm_mask_gen
  import sbm_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int HALF_LANES = LANES / 2
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             half,
  input  logic             dword,
  input  fill_mode_e       mode,
  output logic [LANES-1:0] mask,
  output logic             probe
);
  logic to_addr;
  assign to_addr = (mode == FILL_TO_ADDR);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] IDX  = OFF_W'(i);
    localparam logic [OFF_W-2:0] SUBI = (OFF_W-1)'(i % HALF_LANES);
    localparam logic             UPPER = (i >= HALF_LANES);
    logic sel_dw, sel_w;
    always_comb begin
      sel_dw = to_addr ? (IDX < offset) : (IDX >= offset);
      sel_w  = (UPPER == half) &&
               (to_addr ? (SUBI < offset[OFF_W-2:0]) : (SUBI >= offset[OFF_W-2:0]));
      mask[i] = dword ? sel_dw : sel_w;
    end
  end

  // An end-mode request at offset zero writes nothing but must still probe.
  assign probe = to_addr && (offset == '0);
endmodule

// File: rtl/sbm_lane_place.sv
module sbm_lane_place #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  input  logic              dword,
  output logic [DATA_W-1:0] data
);
  // Big-endian lanes: a word's low half already lines up with its lanes,
  // so the word is mirrored into both halves and the mask picks one.
  always_comb begin
    if (dword) data = value;
    else       data = {2{value[DATA_W/2-1:0]}};
  end
endmodule

// File: rtl/sbyte_merge.sv
module sbyte_merge
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int HALF_LANES = LANES / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_value,
  input  logic              req_end,
  input  logic              req_dword,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_be,
  output logic              wr_probe
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [OFF_W-1:0] offset;
  logic             half;
  fill_mode_e       mode;
  logic [LANES-1:0] mask;
  logic             probe;
  logic [DATA_W-1:0] placed;

  assign mode = fill_mode_e'(req_end);

  sbm_offset_decode #(.LANES(LANES)) u_dec (
    .addr_lo (req_addr[OFF_W-1:0]),
    .dword   (req_dword),
    .offset  (offset),
    .half    (half)
  );

  sbm_mask_gen #(.LANES(LANES)) u_mask (
    .offset (offset),
    .half   (half),
    .dword  (req_dword),
    .mode   (mode),
    .mask   (mask),
    .probe  (probe)
  );

  sbm_lane_place #(.DATA_W(DATA_W)) u_place (
    .value (req_value),
    .dword (req_dword),
    .data  (placed)
  );

  // Next-state logic.
  logic              valid_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic [LANES-1:0]  be_d;
  logic              probe_d;
  logic              load_en;

  always_comb begin
    load_en = req_valid;
    valid_d = req_valid;
    addr_d  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    data_d  = placed;
    be_d    = mask;
    probe_d = probe;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
      wr_probe <= 1'b0;
    end else begin
      wr_valid <= valid_d;
      if (load_en) begin
        wr_addr  <= addr_d;
        wr_data  <= data_d;
        wr_be    <= be_d;
        wr_probe <= probe_d;
      end
    end
  end

  // Assertions.
  p_beat_follows_r10: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> wr_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> !wr_valid);
  p_addr_kept_r2: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> wr_addr[ADDR_W-1:OFF_W] == $past(req_addr[ADDR_W-1:OFF_W]));
  p_probe_empty_r9: assert property (@(posedge clk) disable iff (!rst_q)
    wr_valid && wr_probe |-> wr_be == '0);
  p_begin_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && !req_end |=> wr_be != '0 && !wr_probe);
  p_word_half_r6: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && !req_dword |=>
      ($past(req_addr[OFF_W-1]) ? wr_be[HALF_LANES-1:0] == '0
                                : wr_be[LANES-1:HALF_LANES] == '0));
  p_dword_count_r7: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && req_dword && !req_end |=>
      $countones(wr_be) == LANES - int'($past(req_addr[OFF_W-1:0])));
endmodule

// File: tb/sbyte_merge_bench.sv
module sbyte_merge_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [63:0] req_value;
  logic        req_end;
  logic        req_dword;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;
  logic        wr_probe;

  always #10 clk = ~clk;

  sbyte_merge u_sbyte_merge (
    .clk, .rst_n, .req_valid, .req_addr, .req_value, .req_end, .req_dword,
    .wr_valid, .wr_addr, .wr_data, .wr_be, .wr_probe
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        p_valid = 0;
  logic [31:0] p_addr;
  logic [63:0] p_value;
  logic        p_end;
  logic        p_dword;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_be(logic [31:0] a, logic e, logic dw);
    logic [7:0] m = '0;
    int o    = dw ? int'(a[2:0]) : int'(a[1:0]);
    int n    = dw ? 8 : 4;
    int base = (!dw && a[2]) ? 4 : 0;
    for (int k = 0; k < n; k++)
      if (e ? (k < o) : (k >= o)) m[base + k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] exp_data(logic [63:0] v, logic dw);
    return dw ? v : {v[31:0], v[31:0]};
  endfunction

  function automatic logic [63:0] lane_mask(logic [7:0] be);
    logic [63:0] m = '0;
    for (int k = 0; k < 8; k++) if (be[k]) m[63-8*k -: 8] = 8'hff;
    return m;
  endfunction

  function automatic string mode_tag(logic e, logic dw);
    if (dw) return e ? "R8" : "R7";
    return e ? "R5" : "R4";
  endfunction

  task automatic verify_pending();
    logic [7:0]  eb;
    logic [63:0] lm;
    logic        eprobe;
    if (!p_valid) begin
      check(wr_valid == 1'b0, "R1 idle valid", 64'(wr_valid), 64'd0);
      return;
    end
    check(wr_valid == 1'b1, "R10 beat valid", 64'(wr_valid), 64'd1);
    if (!wr_valid) return;
    eb = exp_be(p_addr, p_end, p_dword);
    lm = lane_mask(eb);
    eprobe = p_end && (p_dword ? (p_addr[2:0] == 0) : (p_addr[1:0] == 0));
    check(wr_addr == {p_addr[31:3], 3'b000}, "R2 addr", 64'(wr_addr),
          64'({p_addr[31:3], 3'b000}));
    check(wr_be == eb, mode_tag(p_end, p_dword), 64'(wr_be), 64'(eb));
    if (!p_dword) begin
      // R6: the half not selected by address bit 2 has no enables.
      check((p_addr[2] ? wr_be[3:0] : wr_be[7:4]) == 4'h0, "R6 other half",
            64'(wr_be), 64'(eb));
    end
    check((wr_data & lm) == (exp_data(p_value, p_dword) & lm), "R3 lane data",
          wr_data & lm, exp_data(p_value, p_dword) & lm);
    check(wr_probe == eprobe, "R9 probe", 64'(wr_probe), 64'(eprobe));
  endtask

  task automatic step(logic v, logic [31:0] a, logic [63:0] val, logic e, logic dw);
    @(negedge clk);
    verify_pending();
    req_valid = v; req_addr = a; req_value = val; req_end = e; req_dword = dw;
    p_valid = v; p_addr = a; p_value = val; p_end = e; p_dword = dw;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_value = '0;
    req_end = 0; req_dword = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wr_valid == 1'b0, "R1 reset valid", 64'(wr_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // Directed: every offset, both modes, both sizes, back to back (R10).
    for (int dw = 0; dw < 2; dw++)
      for (int e = 0; e < 2; e++)
        for (int o = 0; o < 8; o++)
          step(1'b1, 32'h0000_1230 | 32'(o), 64'h8877_6655_4433_2211, e[0], dw[0]);
    step(1'b0, '0, '0, 0, 0);
    step(1'b0, '0, '0, 0, 0);
    // Random traffic with idle gaps.
    for (int i = 0; i < 600; i++)
      step(($urandom % 5) != 0, $urandom, {$urandom, $urandom},
           1'($urandom), 1'($urandom));
    step(1'b0, '0, '0, 0, 0);
    step(1'b0, '0, '0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule